// File: doc/BRIEF.md
# Dual-Bank Sector Protection Decoder

This block sits between a flash command decoder and a 2M x 16 word array that is split into two banks. For each request it turns the 21-bit word address into a bank and a sector number. Bank A covers the lower 512 Kwords. Its first 32 Kwords are cut into eight small 4 Kword boot sectors, and the rest of bank A is fifteen 32 Kword sectors. Bank B covers the upper 1.5 Mwords as forty-eight 32 Kword sectors. That makes 71 sectors, numbered 0 to 70 upward from address zero.

Each sector has a lock bit that software lock and unlock requests set and clear. Program and erase requests pass three protection checks: the sector's lock bit, an active-low write-protect pin that guards the two lowest boot sectors, and a programming-supply input whose low level locks the whole array. A program or erase that passes every check is started, and its bank is marked busy until the embedded-operation engine reports completion. While a bank is busy, reads aimed at the other bank go straight through. Reads aimed at the busy bank are steered to status data instead.

Top module: `bank_sector_guard`

## Requirements
- R1: A request address below 524,288 decodes to bank A (`respBank` = 0). Any higher address decodes to bank B (`respBank` = 1). `respBank` and `respSector` are registered and show the decode of a valid request one cycle after it.
- R2: Sector numbers run as follows. Words 0 to 32,767 form sectors 0 to 7, each 4,096 words. Words 32,768 to 524,287 form sectors 8 to 22, each 32,768 words. Words from 524,288 upward form sectors 23 to 70, each 32,768 words.
- R3: After reset every sector is locked, so each program or erase request is rejected.
- R4: The `reqOp` codes are 0 read, 1 program, 2 sector erase, 3 lock and 4 unlock. Code 3 sets the addressed sector's lock bit and code 4 clears it, and the change applies from the next request. Codes 5 to 7 raise no output pulse.
- R5: While `wpN` is low, program and erase in sectors 0 and 1 are rejected whatever their lock bits hold. Other sectors are unaffected.
- R6: While `progVoltOk` is low, program and erase in every sector are rejected.
- R7: A permitted program or erase gives a one-cycle `grantPulse` one cycle after the request. In that same cycle `busy` rises and `busyBank` shows the request's bank.
- R8: A rejected program or erase gives a one-cycle `violPulse` one cycle after the request, with no grant and no change to `busy`. At most one of `grantPulse`, `violPulse`, `statusSel` and `readGo` is high in any cycle.
- R9: A read gives `readGo` one cycle later when no operation is running, or when it targets the bank that is not busy.
- R10: A read to the busy bank gives `statusSel` one cycle later instead of `readGo`.
- R11: A program or erase requested while `busy` is high gives neither a grant nor a violation and leaves `busy` and `busyBank` unchanged.
- R12: `opDone` clears `busy` at the next edge, and until then `busy` and `busyBank` hold. A program request made in the same cycle as `opDone` still sees the bank busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 3 | Request code (see R4) |
| reqAddr | input | 21 | Word address of the request |
| wpN | input | 1 | Active-low write protect for sectors 0 and 1 |
| progVoltOk | input | 1 | Programming supply valid; low locks all sectors |
| opDone | input | 1 | Embedded operation finished |
| grantPulse | output | 1 | Program or erase started |
| violPulse | output | 1 | Program or erase rejected by protection |
| statusSel | output | 1 | Read must return status bits |
| readGo | output | 1 | Read may return array data |
| respBank | output | 1 | Bank of the last request |
| respSector | output | 7 | Sector of the last request |
| busy | output | 1 | An embedded operation is running |
| busyBank | output | 1 | Bank of the running operation |

## Verification
The bound checker watches, on every cycle, the properties that only involve timing and state. The result pulses never overlap. A grant always comes with the busy flag. Nothing is granted in the cycle after busy, or in the cycle after a low programming supply. Status steering only happens while busy was set. Busy holds until `opDone`. Address decoding at every sector edge, the reset lock state, lock and unlock per sector, and the write-protect scope can only be shown by the bench's sweeps across all 71 sectors.

// File: rtl/guard_pkg.sv
package guard_pkg;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_LOCK   = 3'd3,
    OP_UNLOCK = 3'd4
  } opKind_e;

  // strobes from control to datapath, one request per cycle
  typedef struct packed {
    logic capture;
    logic setLock;
    logic clrLock;
    logic start;
    logic viol;
    logic status;
    logic readOk;
  } guardStb_t;

endpackage

// File: rtl/sector_map.sv
module sector_map #(
  parameter int ADDR_W    = 21,
  parameter int SMALL_CNT = 8,
  parameter int SMALL_W   = 12,
  parameter int BIG_W     = 15,
  parameter int A_BIG     = 15,
  parameter int SECT_W    = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              bank,
  output logic [SECT_W-1:0] sect
);
  localparam int SMALL_SPAN = SMALL_CNT << SMALL_W;
  localparam int A_END      = SMALL_SPAN + (A_BIG << BIG_W);

  logic [ADDR_W-1:0] offA;
  logic [ADDR_W-1:0] offB;

  assign offA = addr - ADDR_W'(SMALL_SPAN);
  assign offB = addr - ADDR_W'(A_END);

  always_comb begin
    if (addr < ADDR_W'(SMALL_SPAN)) begin
      bank = 1'b0;
      sect = SECT_W'(addr >> SMALL_W);
    end else if (addr < ADDR_W'(A_END)) begin
      bank = 1'b0;
      sect = SECT_W'(SMALL_CNT) + SECT_W'(offA >> BIG_W);
    end else begin
      bank = 1'b1;
      sect = SECT_W'(SMALL_CNT + A_BIG) + SECT_W'(offB >> BIG_W);
    end
  end
endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import guard_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic [2:0] reqOp,
  input  logic      reqBank,
  input  logic      sectProt,
  input  logic      opDone,
  output guardStb_t stb,
  output logic      busy,
  output logic      busyBank
);
  opKind_e opKind;
  assign opKind = opKind_e'(reqOp);

  always_comb begin
    stb = '0;
    stb.capture = reqValid;
    if (reqValid) begin
      case (opKind)
        OP_READ: begin
          if (busy && (reqBank == busyBank)) stb.status = 1'b1;
          else                               stb.readOk = 1'b1;
        end
        OP_PROG, OP_ERASE: begin
          if (!busy) begin
            if (sectProt) stb.viol  = 1'b1;
            else          stb.start = 1'b1;
          end
        end
        OP_LOCK:   stb.setLock = 1'b1;
        OP_UNLOCK: stb.clrLock = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      busyBank <= 1'b0;
    end else if (stb.start) begin
      busy     <= 1'b1;
      busyBank <= reqBank;
    end else if (opDone) begin
      busy     <= 1'b0;
    end
  end
endmodule

// File: rtl/guard_dp.sv
module guard_dp
  import guard_pkg::*;
#(
  parameter int NUM_SECT   = 71,
  parameter int SECT_W     = 7,
  parameter int BOOT_GUARD = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStb_t         stb,
  input  logic              reqBank,
  input  logic [SECT_W-1:0] reqSect,
  input  logic              wpN,
  input  logic              progVoltOk,
  output logic              sectProt,
  output logic              grantPulse,
  output logic              violPulse,
  output logic              statusSel,
  output logic              readGo,
  output logic              respBank,
  output logic [SECT_W-1:0] respSector
);
  logic [NUM_SECT-1:0] lockBits;
  logic [NUM_SECT-1:0] bootMask;

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    assign bootMask[s] = (s < BOOT_GUARD);
    always_ff @(posedge clk) begin
      if (!rstN)
        lockBits[s] <= 1'b1;
      else if (stb.setLock && reqSect == SECT_W'(s))
        lockBits[s] <= 1'b1;
      else if (stb.clrLock && reqSect == SECT_W'(s))
        lockBits[s] <= 1'b0;
    end
  end

  assign sectProt = lockBits[reqSect] | (~wpN & bootMask[reqSect]) | ~progVoltOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantPulse <= 1'b0;
      violPulse  <= 1'b0;
      statusSel  <= 1'b0;
      readGo     <= 1'b0;
      respBank   <= 1'b0;
      respSector <= '0;
    end else begin
      grantPulse <= stb.start;
      violPulse  <= stb.viol;
      statusSel  <= stb.status;
      readGo     <= stb.readOk;
      if (stb.capture) begin
        respBank   <= reqBank;
        respSector <= reqSect;
      end
    end
  end
endmodule

// File: rtl/bank_sector_guard.sv
module bank_sector_guard
  import guard_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int SMALL_CNT = 8,
  parameter int SMALL_W   = 12,
  parameter int BIG_W     = 15,
  parameter int A_BIG     = 15,
  parameter int B_BIG     = 48,
  parameter int BOOT_GUARD = 2,
  localparam int NUM_SECT = SMALL_CNT + A_BIG + B_BIG,
  localparam int SECT_W   = $clog2(NUM_SECT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              wpN,
  input  logic              progVoltOk,
  input  logic              opDone,
  output logic              grantPulse,
  output logic              violPulse,
  output logic              statusSel,
  output logic              readGo,
  output logic              respBank,
  output logic [SECT_W-1:0] respSector,
  output logic              busy,
  output logic              busyBank
);
  logic              reqBank;
  logic [SECT_W-1:0] reqSect;
  logic              sectProt;
  guardStb_t         stb;

  sector_map #(
    .ADDR_W(ADDR_W), .SMALL_CNT(SMALL_CNT), .SMALL_W(SMALL_W),
    .BIG_W(BIG_W), .A_BIG(A_BIG), .SECT_W(SECT_W)
  ) i_map (
    .addr(reqAddr), .bank(reqBank), .sect(reqSect)
  );

  guard_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqBank(reqBank), .sectProt(sectProt), .opDone(opDone),
    .stb(stb), .busy(busy), .busyBank(busyBank)
  );

  guard_dp #(
    .NUM_SECT(NUM_SECT), .SECT_W(SECT_W), .BOOT_GUARD(BOOT_GUARD)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqBank(reqBank), .reqSect(reqSect),
    .wpN(wpN), .progVoltOk(progVoltOk), .sectProt(sectProt),
    .grantPulse(grantPulse), .violPulse(violPulse), .statusSel(statusSel),
    .readGo(readGo), .respBank(respBank), .respSector(respSector)
  );
endmodule

// File: rtl/guard_chk.sv
module guard_chk #(
  parameter int ADDR_W = 21,
  parameter int SECT_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [2:0]        reqOp,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              wpN,
  input logic              progVoltOk,
  input logic              opDone,
  input logic              grantPulse,
  input logic              violPulse,
  input logic              statusSel,
  input logic              readGo,
  input logic              respBank,
  input logic [SECT_W-1:0] respSector,
  input logic              busy,
  input logic              busyBank
);
  // R8
  one_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({grantPulse, violPulse, statusSel, readGo}));

  // R7
  grant_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    grantPulse |-> busy);

  // R6
  supply_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(reqValid) && !$past(progVoltOk)) |-> !grantPulse);

  // R11
  busy_no_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> !grantPulse);

  // R10
  status_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusSel |-> $past(busy));

  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !opDone) |=> (busy && $stable(busyBank)));
endmodule

bind bank_sector_guard guard_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_chk (.*);

// File: tb/test_bank_sector_guard.sv
`timescale 1ns/1ps
module test_bank_sector_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = 3'd0;
  logic [20:0] reqAddr = '0;
  logic        wpN = 1'b1;
  logic        progVoltOk = 1'b1;
  logic        opDone = 1'b0;
  logic        grantPulse, violPulse, statusSel, readGo, respBank, busy, busyBank;
  logic [6:0]  respSector;

  int vecCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bank_sector_guard i_bank_sector_guard (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .wpN(wpN), .progVoltOk(progVoltOk), .opDone(opDone),
    .grantPulse(grantPulse), .violPulse(violPulse), .statusSel(statusSel),
    .readGo(readGo), .respBank(respBank), .respSector(respSector),
    .busy(busy), .busyBank(busyBank)
  );

  localparam logic [3:0] E_NONE = 4'b0000, E_GRANT = 4'b1000, E_VIOL = 4'b0100,
                         E_STAT = 4'b0010, E_READ = 4'b0001;

  function automatic int sectBase(int s);
    if (s < 8)  return s * 4096;
    if (s < 23) return 32768 + (s - 8) * 32768;
    return 524288 + (s - 23) * 32768;
  endfunction

  function automatic int sectSize(int s);
    return (s < 8) ? 4096 : 32768;
  endfunction

  function automatic int bankOf(int s);
    return (s < 23) ? 0 : 1;
  endfunction

  task automatic check(string tag, int got, int exp);
    vecCount++;
    if (got != exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic issue(logic [2:0] op, int addr, bit withDone = 1'b0);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = 21'(addr); opDone = withDone;
    @(negedge clk);
    reqValid = 1'b0; reqOp = 3'd0; opDone = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk); opDone = 1'b1;
    @(negedge clk); opDone = 1'b0;
  endtask

  function automatic int outs();
    return {grantPulse, violPulse, statusSel, readGo};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("reset outputs", outs(), E_NONE);
    check("reset busy", busy, 0);

    // R1 R2 R9: decode sweep over every sector edge, idle reads
    for (int s = 0; s < 71; s++) begin
      for (int e = 0; e < 2; e++) begin
        int a;
        a = (e == 0) ? sectBase(s) : sectBase(s) + sectSize(s) - 1;
        issue(3'd0, a);
        check($sformatf("R1 bank addr %0d", a), respBank, bankOf(s));
        check($sformatf("R2 sector addr %0d", a), respSector, s);
        check("R9 idle read", outs(), E_READ);
      end
    end

    // R4: undefined codes give no pulse
    issue(3'd6, 100);
    check("R4 unused code", outs(), E_NONE);

    for (int s = 0; s < 71; s++) begin
      int a, other;
      a = sectBase(s) + 7;
      other = (bankOf(s) == 0) ? 524288 + 5 : 9;
      issue(3'd1, a);
      check($sformatf("R3 reset lock s%0d", s), outs(), E_VIOL);
      check("R8 busy after reject", busy, 0);
      issue(3'd4, a);
      issue(3'd1, a);
      check($sformatf("R7 grant s%0d", s), outs(), E_GRANT);
      check("R7 busy", busy, 1);
      check("R7 busyBank", busyBank, bankOf(s));
      issue(3'd0, a + 1);
      check("R10 busy bank read", outs(), E_STAT);
      issue(3'd0, other);
      check("R9 other bank read", outs(), E_READ);
      issue(3'd2, a);
      check("R11 erase while busy", outs(), E_NONE);
      check("R11 busy kept", busy, 1);
      check("R11 bank kept", busyBank, bankOf(s));
      pulseDone();
      check("R12 done clears", busy, 0);
      issue(3'd2, a);
      check("R7 erase grant", outs(), E_GRANT);
      pulseDone();
      issue(3'd3, a);
      issue(3'd2, a);
      check($sformatf("R4 relock s%0d", s), outs(), E_VIOL);
    end

    // R5: write-protect scope
    for (int s = 0; s < 3; s++) issue(3'd4, sectBase(s));
    wpN = 1'b0;
    for (int s = 0; s < 3; s++) begin
      issue(3'd1, sectBase(s));
      check($sformatf("R5 wp s%0d", s), outs(), (s < 2) ? E_VIOL : E_GRANT);
      if (s == 2) pulseDone();
    end
    wpN = 1'b1;
    issue(3'd2, sectBase(1));
    check("R5 wp released", outs(), E_GRANT);
    pulseDone();

    // R6: supply low locks everything
    progVoltOk = 1'b0;
    for (int s = 0; s < 3; s++) begin
      issue(3'd1, sectBase(s) + 3);
      check($sformatf("R6 supply low s%0d", s), outs(), E_VIOL);
    end
    progVoltOk = 1'b1;

    // R12: request in the same cycle as opDone still sees busy
    issue(3'd1, sectBase(2));
    check("R12 setup grant", outs(), E_GRANT);
    issue(3'd1, sectBase(2), 1'b1);
    check("R12 same-cycle request", outs(), E_NONE);
    check("R12 busy cleared", busy, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule